// File: doc/BRIEF.md
# Display Timing Generator with Shadowed Timing Registers

This block produces horizontal sync, vertical sync and data-enable for a parallel RGB panel. It also reports its current pixel and line position for the layer logic. Software programs the timing through a write-only register port. Each timing word holds a horizontal field in bits [27:16] and a vertical field in bits [10:0]. Every field stores a cumulative edge position: the sync length minus one, that value plus the back porch, that value plus the active size, and finally that value plus the front porch.

The four timing words are written into a shadow copy. The counters never use the shadow copy directly. A reload request moves the whole set into the working copy in one step. The request is either immediate or waits for the start of vertical blanking, so a new mode never takes effect halfway through a frame. A small interrupt unit collects four event kinds: a programmable line position, FIFO underrun, transfer error and reload completion. Each kind has its own enable bit and write-one-to-clear bit.

Register word addresses on `wr_addr`: 0 sync, 1 back porch, 2 active, 3 total, 4 global control, 5 reload request, 6 interrupt enable, 7 interrupt clear, 8 line position. Polarity, enable, interrupt enable and line position take effect on the clock edge of the write.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the controller is disabled. `hcount_o` and `vcount_o` are 0, `hsync_o`, `vsync_o` and `de_o` are 1 (inactive, active low), `pclk_inv_o`, `irq_o`, `irq_status_o` and `reload_busy_o` are 0.
- R2: While global control bit 0 is 1, `hcount_o` counts from 0 up to the working total-width field (word 3, bits [27:16]) and then returns to 0. `vcount_o` advances at each such wrap and returns to 0 after the total-height field (word 3, bits [10:0]). While bit 0 is 0, both counters are 0 from the next cycle on.
- R3: `hsync` is active while the controller is enabled and `hcount_o` ≤ word 0 bits [27:16]. `vsync` is active while the controller is enabled and `vcount_o` ≤ word 0 bits [10:0].
- R4: `de` is active while the controller is enabled, word 1 h < `hcount_o` ≤ word 2 h, and word 1 v < `vcount_o` ≤ word 2 v.
- R5: All three outputs are active low by default. Global control bit 31 makes hsync active high, bit 30 makes vsync active high and bit 29 makes de active high. Bit 28 drives `pclk_inv_o`. While the controller is disabled, each output sits at its inactive level.
- R6: Writes to words 0–3 do not change the working timing until a reload completes.
- R7: Writing word 5 with bit 0 set raises `reload_busy_o[0]`. On the next clock edge the shadow set is copied and the bit clears.
- R8: Writing word 5 with bit 1 set raises `reload_busy_o[1]`. The copy happens, and the bit clears, at the edge where `hcount_o` wraps while `vcount_o` equals the working active-height field. After that edge `vcount_o` is that field plus one and `hcount_o` is 0.
- R9: Status bits are line (0), underrun (1), transfer error (2) and reload done (3). They use the same positions in word 6 (enable) and word 7 (write 1 to clear). A status bit is set only when its enable bit is 1. `irq_o` is the OR of the status bits.
- R10: Status bit 0 becomes set in the same cycle that `vcount_o` takes the value of word 8.
- R11: If an event and a clear of the same status bit fall in one cycle, the bit ends up set.
- R12: An immediate reload also satisfies a pending blanking reload. When both are requested together, both busy bits are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| underrun_i | input | 1 | FIFO underrun event pulse |
| xfer_err_i | input | 1 | Transfer error event pulse |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| de_o | output | 1 | Data-enable pin level |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| hcount_o | output | 12 | Current pixel position |
| vcount_o | output | 11 | Current line position |
| irq_status_o | output | 4 | Interrupt status bits |
| reload_busy_o | output | 2 | Pending reload requests (bit 0 immediate, bit 1 blanking) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is an event and a software clear of the same status bit. The bench pulses `underrun_i` in exactly the cycle that writes 1 to clear bit 1. It then expects the bit to remain set, and a later clear on its own to remove it.

The second pair is the two reload kinds. A single write requests both. Both busy bits must drop one edge later, with the new timing in force at once rather than at blanking.

A reference model, fed the same writes and pulses, predicts every output for every cycle. This also catches any change that lands at the wrong position within a frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int ADDR_W   = 4;
    localparam int NUM_IRQ  = 4;
    localparam int NUM_TREG = 4;
    localparam int H_LSB    = 16;

    // timing word indices (position in the timing array)
    localparam int T_SYNC   = 0;
    localparam int T_BPORCH = 1;
    localparam int T_ACTIVE = 2;
    localparam int T_TOTAL  = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_GCTL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd5;
    localparam logic [ADDR_W-1:0] A_IEN    = 4'd6;
    localparam logic [ADDR_W-1:0] A_ICLR   = 4'd7;
    localparam logic [ADDR_W-1:0] A_LPOS   = 4'd8;

    // global control bit positions
    localparam int B_EN    = 0;
    localparam int B_PCLK  = 28;
    localparam int B_DEPOL = 29;
    localparam int B_VSPOL = 30;
    localparam int B_HSPOL = 31;

    // reload request bits
    localparam int RL_IMM = 0;
    localparam int RL_VBL = 1;

    // interrupt bit positions
    localparam int IRQ_LINE = 0;
    localparam int IRQ_UNDR = 1;
    localparam int IRQ_TERR = 2;
    localparam int IRQ_RLD  = 3;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [31:0]                        wr_data,
    input  logic                               vbl_start,
    output logic [NUM_TREG-1:0][HW-1:0]        act_h,
    output logic [NUM_TREG-1:0][VW-1:0]        act_v,
    output logic                               ctl_en,
    output logic                               pol_hs,
    output logic                               pol_vs,
    output logic                               pol_de,
    output logic                               pclk_inv,
    output logic [VW-1:0]                      lpos,
    output logic [NUM_IRQ-1:0]                 ien,
    output logic [NUM_IRQ-1:0]                 iclr,
    output logic [1:0]                         busy,
    output logic                               reload_done
);
    typedef struct packed {
        logic [NUM_TREG-1:0][HW-1:0] sh_h;
        logic [NUM_TREG-1:0][VW-1:0] sh_v;
        logic [NUM_TREG-1:0][HW-1:0] ac_h;
        logic [NUM_TREG-1:0][VW-1:0] ac_v;
        logic                        en;
        logic                        hspol;
        logic                        vspol;
        logic                        depol;
        logic                        pclk;
        logic [VW-1:0]               lpos;
        logic [NUM_IRQ-1:0]          ien;
        logic [1:0]                  req;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       done_imm, done_vbl;
    logic       wr_unused;

    assign wr_unused = ^wr_data;

    always_comb begin
        st_d     = st_q;
        done_imm = st_q.req[RL_IMM];
        done_vbl = st_q.req[RL_VBL] & vbl_start;

        // commit uses the shadow contents as they stood before this edge
        if (done_imm || done_vbl) begin
            st_d.ac_h = st_q.sh_h;
            st_d.ac_v = st_q.sh_v;
        end
        if (done_imm) begin
            st_d.req = 2'b00;
        end else if (done_vbl) begin
            st_d.req[RL_VBL] = 1'b0;
        end

        for (int i = 0; i < NUM_TREG; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i)) begin
                st_d.sh_h[i] = wr_data[H_LSB +: HW];
                st_d.sh_v[i] = wr_data[0 +: VW];
            end
        end

        if (wr_en) begin
            case (wr_addr)
                A_GCTL: begin
                    st_d.en    = wr_data[B_EN];
                    st_d.pclk  = wr_data[B_PCLK];
                    st_d.depol = wr_data[B_DEPOL];
                    st_d.vspol = wr_data[B_VSPOL];
                    st_d.hspol = wr_data[B_HSPOL];
                end
                A_RELOAD: st_d.req  = st_d.req | wr_data[1:0];
                A_IEN:    st_d.ien  = wr_data[NUM_IRQ-1:0];
                A_LPOS:   st_d.lpos = wr_data[VW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_h       = st_q.ac_h;
    assign act_v       = st_q.ac_v;
    assign ctl_en      = st_q.en;
    assign pol_hs      = st_q.hspol;
    assign pol_vs      = st_q.vspol;
    assign pol_de      = st_q.depol;
    assign pclk_inv    = st_q.pclk;
    assign lpos        = st_q.lpos;
    assign ien         = st_q.ien;
    assign busy        = st_q.req;
    assign reload_done = done_imm | done_vbl;
    assign iclr        = (wr_en && wr_addr == A_ICLR) ? wr_data[NUM_IRQ-1:0] : '0;
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_act_end,
    input  logic [VW-1:0] line_pos,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          line_hit,
    output logic          vbl_start
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic h_wrap, v_wrap;

    always_comb begin
        h_wrap = (cnt_q.h >= h_total);
        v_wrap = (cnt_q.v >= v_total);
        cnt_d  = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (h_wrap) begin
            cnt_d.h = '0;
            cnt_d.v = v_wrap ? '0 : cnt_q.v + 1'b1;
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
        line_hit  = en && h_wrap && (cnt_d.v == line_pos);
        vbl_start = en && h_wrap && (cnt_q.v == v_act_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hcnt = cnt_q.h;
    assign vcnt = cnt_q.v;
endmodule

// File: rtl/dtg_outfmt.sv
module dtg_outfmt #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          en,
    input  logic          pol_hs,
    input  logic          pol_vs,
    input  logic          pol_de,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic [HW-1:0] hs_end,
    input  logic [VW-1:0] vs_end,
    input  logic [HW-1:0] h_bp_end,
    input  logic [VW-1:0] v_bp_end,
    input  logic [HW-1:0] h_act_end,
    input  logic [VW-1:0] v_act_end,
    output logic          hsync,
    output logic          vsync,
    output logic          de
);
    logic hs_act, vs_act, de_act, h_win, v_win;

    always_comb begin
        hs_act = en && (hcnt <= hs_end);
        vs_act = en && (vcnt <= vs_end);
        h_win  = (hcnt > h_bp_end) && (hcnt <= h_act_end);
        v_win  = (vcnt > v_bp_end) && (vcnt <= v_act_end);
        de_act = en && h_win && v_win;
        hsync  = pol_hs ? hs_act : !hs_act;
        vsync  = pol_vs ? vs_act : !vs_act;
        de     = pol_de ? de_act : !de_act;
    end
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    input  logic [N-1:0] enables,
    input  logic [N-1:0] clears,
    output logic [N-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flags;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // a new event wins over a clear of the same bit
        s_d.flags = (s_q.flags & ~clears) | (events & enables);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.flags;
    assign irq    = |s_q.flags;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int HCNT_W = 12,
    parameter int VCNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              underrun_i,
    input  logic              xfer_err_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pclk_inv_o,
    output logic [HCNT_W-1:0] hcount_o,
    output logic [VCNT_W-1:0] vcount_o,
    output logic [3:0]        irq_status_o,
    output logic [1:0]        reload_busy_o,
    output logic              irq_o
);
    logic [NUM_TREG-1:0][HCNT_W-1:0] act_h;
    logic [NUM_TREG-1:0][VCNT_W-1:0] act_v;
    logic                            ctl_en, pol_hs, pol_vs, pol_de;
    logic [VCNT_W-1:0]               lpos_q;
    logic [NUM_IRQ-1:0]              ien_q, iclr, irq_ev;
    logic                            reload_done, line_hit, vbl_start;

    dtg_regs #(.HW(HCNT_W), .VW(VCNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .vbl_start   (vbl_start),
        .act_h       (act_h),
        .act_v       (act_v),
        .ctl_en      (ctl_en),
        .pol_hs      (pol_hs),
        .pol_vs      (pol_vs),
        .pol_de      (pol_de),
        .pclk_inv    (pclk_inv_o),
        .lpos        (lpos_q),
        .ien         (ien_q),
        .iclr        (iclr),
        .busy        (reload_busy_o),
        .reload_done (reload_done)
    );

    dtg_counters #(.HW(HCNT_W), .VW(VCNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .h_total   (act_h[T_TOTAL]),
        .v_total   (act_v[T_TOTAL]),
        .v_act_end (act_v[T_ACTIVE]),
        .line_pos  (lpos_q),
        .hcnt      (hcount_o),
        .vcnt      (vcount_o),
        .line_hit  (line_hit),
        .vbl_start (vbl_start)
    );

    dtg_outfmt #(.HW(HCNT_W), .VW(VCNT_W)) u_fmt (
        .en        (ctl_en),
        .pol_hs    (pol_hs),
        .pol_vs    (pol_vs),
        .pol_de    (pol_de),
        .hcnt      (hcount_o),
        .vcnt      (vcount_o),
        .hs_end    (act_h[T_SYNC]),
        .vs_end    (act_v[T_SYNC]),
        .h_bp_end  (act_h[T_BPORCH]),
        .v_bp_end  (act_v[T_BPORCH]),
        .h_act_end (act_h[T_ACTIVE]),
        .v_act_end (act_v[T_ACTIVE]),
        .hsync     (hsync_o),
        .vsync     (vsync_o),
        .de        (de_o)
    );

    always_comb begin
        irq_ev           = '0;
        irq_ev[IRQ_LINE] = line_hit;
        irq_ev[IRQ_UNDR] = underrun_i;
        irq_ev[IRQ_TERR] = xfer_err_i;
        irq_ev[IRQ_RLD]  = reload_done;
    end

    dtg_irq #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (irq_ev),
        .enables (ien_q),
        .clears  (iclr),
        .status  (irq_status_o),
        .irq     (irq_o)
    );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [3:0]    wr_addr,
    input logic [31:0]   wr_data,
    input logic          ctl_en,
    input logic          pol_hs,
    input logic          pol_vs,
    input logic          pol_de,
    input logic [3:0]    ien,
    input logic [VW-1:0] lpos,
    input logic [HW-1:0] hcount_o,
    input logic [VW-1:0] vcount_o,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          de_o,
    input logic [3:0]    irq_status_o,
    input logic [1:0]    reload_busy_o
);
    logic rl_wr;
    assign rl_wr = wr_en && (wr_addr == 4'd5);

    AST_CNT_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (hcount_o == '0) && (vcount_o == '0)); // R2

    AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && hcount_o != '0) |-> hcount_o == HW'($past(hcount_o) + 1'b1)); // R2

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (hsync_o != pol_hs) && (vsync_o != pol_vs) && (de_o != pol_de)); // R5

    AST_IMM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_busy_o[0] && !(rl_wr && wr_data[0])) |=> !reload_busy_o[0]); // R7

    AST_BOTH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_busy_o == 2'b11 && !(rl_wr && |wr_data[1:0])) |=> reload_busy_o == 2'b00); // R12

    AST_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status_o[1]) |-> $past(ien[1])); // R9

    AST_LINE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status_o[0]) |-> (vcount_o == $past(lpos)) && (hcount_o == '0)); // R10
endmodule

bind disp_timing_gen dtg_checker #(.HW(HCNT_W), .VW(VCNT_W)) u_dtg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ctl_en        (ctl_en),
    .pol_hs        (pol_hs),
    .pol_vs        (pol_vs),
    .pol_de        (pol_de),
    .ien           (ien_q),
    .lpos          (lpos_q),
    .hcount_o      (hcount_o),
    .vcount_o      (vcount_o),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .de_o          (de_o),
    .irq_status_o  (irq_status_o),
    .reload_busy_o (reload_busy_o)
);

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        underrun_i = 1'b0;
    logic        xfer_err_i = 1'b0;
    logic        hsync_o, vsync_o, de_o, pclk_inv_o, irq_o;
    logic [11:0] hcount_o;
    logic [10:0] vcount_o;
    logic [3:0]  irq_status_o;
    logic [1:0]  reload_busy_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    disp_timing_gen u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .underrun_i(underrun_i), .xfer_err_i(xfer_err_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_inv_o(pclk_inv_o),
        .hcount_o(hcount_o), .vcount_o(vcount_o), .irq_status_o(irq_status_o),
        .reload_busy_o(reload_busy_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model + scoreboard ----------------
    typedef struct {
        bit       rst;
        int       h, v;
        bit       hs, vs, de, pc, irq;
        bit [3:0] st;
        bit [1:0] busy;
    } exp_t;

    exp_t exp_q[$];

    int       m_sh_h[4], m_sh_v[4], m_ac_h[4], m_ac_v[4];
    bit       m_en, m_hp, m_vp, m_dp, m_pc;
    int       m_lpos, m_h, m_v;
    bit [3:0] m_ien, m_st;
    bit [1:0] m_req;

    always @(posedge clk) begin
        exp_t e;
        bit hwrap, vbl, lhit, d_i, d_v, hs_a, vs_a, de_a;
        int nh, nv;
        bit [3:0] ev, clr;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_sh_h[i] = 0; m_sh_v[i] = 0; m_ac_h[i] = 0; m_ac_v[i] = 0;
            end
            {m_en, m_hp, m_vp, m_dp, m_pc} = '0;
            m_lpos = 0; m_h = 0; m_v = 0; m_ien = 0; m_st = 0; m_req = 0;
        end else begin
            hwrap = m_h >= m_ac_h[3];
            nh = 0; nv = 0;
            if (m_en) begin
                nh = hwrap ? 0 : m_h + 1;
                nv = hwrap ? ((m_v >= m_ac_v[3]) ? 0 : m_v + 1) : m_v;
            end
            vbl  = m_en && hwrap && (m_v == m_ac_v[2]);
            lhit = m_en && hwrap && (nv == m_lpos);
            d_i  = m_req[0];
            d_v  = m_req[1] && vbl;
            ev   = {d_i | d_v, xfer_err_i, underrun_i, lhit};
            clr  = (wr_en && wr_addr == 4'd7) ? wr_data[3:0] : 4'd0;
            m_st = (m_st & ~clr) | (ev & m_ien);
            if (d_i || d_v) begin
                for (int i = 0; i < 4; i++) begin
                    m_ac_h[i] = m_sh_h[i]; m_ac_v[i] = m_sh_v[i];
                end
            end
            if (d_i) m_req = 0; else if (d_v) m_req[1] = 0;
            if (wr_en) begin
                if (wr_addr < 4'd4) begin
                    m_sh_h[wr_addr] = int'(wr_data[27:16]);
                    m_sh_v[wr_addr] = int'(wr_data[10:0]);
                end
                case (wr_addr)
                    4'd4: begin
                        m_en = wr_data[0]; m_pc = wr_data[28]; m_dp = wr_data[29];
                        m_vp = wr_data[30]; m_hp = wr_data[31];
                    end
                    4'd5: m_req = m_req | wr_data[1:0];
                    4'd6: m_ien = wr_data[3:0];
                    4'd8: m_lpos = int'(wr_data[10:0]);
                    default: ;
                endcase
            end
            m_h = nh; m_v = nv;
        end
        hs_a = m_en && (m_h <= m_ac_h[0]);
        vs_a = m_en && (m_v <= m_ac_v[0]);
        de_a = m_en && (m_h > m_ac_h[1]) && (m_h <= m_ac_h[2]) &&
               (m_v > m_ac_v[1]) && (m_v <= m_ac_v[2]);
        e.rst  = !rst_n;
        e.h    = m_h;
        e.v    = m_v;
        e.hs   = m_hp ? hs_a : !hs_a;
        e.vs   = m_vp ? vs_a : !vs_a;
        e.de   = m_dp ? de_a : !de_a;
        e.pc   = m_pc;
        e.st   = m_st;
        e.irq  = |m_st;
        e.busy = m_req;
        exp_q.push_back(e);
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(hcount_o == e.h,       e.rst ? "R1 hcount" : "R2 hcount", hcount_o, e.h);
            chk(vcount_o == e.v,       e.rst ? "R1 vcount" : "R2 vcount", vcount_o, e.v);
            chk(hsync_o == e.hs,       e.rst ? "R1 hsync"  : "R3 hsync",  hsync_o, e.hs);
            chk(vsync_o == e.vs,       e.rst ? "R1 vsync"  : "R3 vsync",  vsync_o, e.vs);
            chk(de_o == e.de,          e.rst ? "R1 de"     : "R4 de",     de_o, e.de);
            chk(pclk_inv_o == e.pc,    e.rst ? "R1 pclk"   : "R5 pclk",   pclk_inv_o, e.pc);
            chk(irq_status_o == e.st,  e.rst ? "R1 status" : "R9 status", irq_status_o, e.st);
            chk(irq_o == e.irq,        e.rst ? "R1 irq"    : "R9 irq",    irq_o, e.irq);
            chk(reload_busy_o == e.busy, e.rst ? "R1 busy" : "R7 busy",   reload_busy_o, e.busy);
        end
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset levels
        chk(hsync_o == 1 && vsync_o == 1 && de_o == 1, "R1 idle pins", {hsync_o, vsync_o, de_o}, 7);
        chk(irq_o == 0 && hcount_o == 0, "R1 irq/count", {irq_o, hcount_o}, 0);
        rst_n = 1'b1;

        wr(4'd0, 32'h0001_0000);
        wr(4'd1, 32'h0003_0001);
        wr(4'd2, 32'h000B_0005);
        wr(4'd3, 32'h000D_0007);
        wr(4'd4, 32'h0000_0001);
        repeat (5) @(negedge clk);
        // R6: shadow contents not in use yet (working total still zero)
        chk(hcount_o == 0 && vcount_o == 0, "R6 shadow unused", hcount_o, 0);

        wr(4'd5, 32'h1);
        chk(reload_busy_o == 2'b01, "R7 request raised", reload_busy_o, 1);
        @(negedge clk);
        chk(reload_busy_o == 2'b00, "R7 request cleared", reload_busy_o, 0);
        // R9: reload completed with enables off, no status
        chk(irq_status_o == 0, "R9 masked reload", irq_status_o, 0);
        repeat (230) @(negedge clk);

        // R10 line interrupt at line 3
        wr(4'd8, 32'd3);
        wr(4'd6, 32'h1);
        wr(4'd7, 32'hF);
        while (!irq_status_o[0]) @(negedge clk);
        chk(vcount_o == 3 && hcount_o == 0, "R10 line position", {vcount_o, hcount_o}, 3 << 12);
        wr(4'd6, 32'hE);
        wr(4'd7, 32'hF);

        // R11 event and clear in the same cycle
        @(negedge clk);
        underrun_i = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'h2;
        @(negedge clk);
        underrun_i = 1'b0; wr_en = 1'b0;
        chk(irq_status_o[1] == 1'b1, "R11 set beats clear", irq_status_o[1], 1);
        wr(4'd7, 32'h2);
        chk(irq_status_o[1] == 1'b0, "R9 clear", irq_status_o[1], 0);

        // R9 enable gating
        wr(4'd6, 32'h0);
        @(negedge clk); xfer_err_i = 1'b1; @(negedge clk); xfer_err_i = 1'b0;
        chk(irq_status_o[2] == 0 && irq_o == 0, "R9 masked event", irq_status_o, 0);
        wr(4'd6, 32'hC);
        @(negedge clk); xfer_err_i = 1'b1; @(negedge clk); xfer_err_i = 1'b0;
        chk(irq_status_o[2] == 1 && irq_o == 1, "R9 enabled event", irq_status_o[2], 1);
        wr(4'd7, 32'hF);

        // R5 polarity inversion
        wr(4'd4, 32'hF000_0001);
        chk(pclk_inv_o == 1, "R5 pclk inversion", pclk_inv_o, 1);
        while (!(hcount_o == 5 && vcount_o == 3)) @(negedge clk);
        chk(de_o == 1 && hsync_o == 0, "R5 de high-active", {de_o, hsync_o}, 2);
        repeat (150) @(negedge clk);

        // R8 blanking reload with a new timing set
        wr(4'd0, 32'h0002_0001);
        wr(4'd1, 32'h0005_0003);
        wr(4'd2, 32'h000F_0008);
        wr(4'd3, 32'h0012_000A);
        wr(4'd5, 32'h2);
        chk(reload_busy_o == 2'b10, "R8 request raised", reload_busy_o, 2);
        while (reload_busy_o[1]) @(negedge clk);
        chk(vcount_o == 6 && hcount_o == 0, "R8 commit at blanking", {vcount_o, hcount_o}, 6 << 12);
        chk(irq_status_o[3] == 1, "R9 reload status", irq_status_o[3], 1);
        wr(4'd7, 32'hF);
        repeat (450) @(negedge clk);

        // R12 both reload kinds at once
        wr(4'd1, 32'h0004_0002);
        wr(4'd5, 32'h3);
        chk(reload_busy_o == 2'b11, "R12 both raised", reload_busy_o, 3);
        @(negedge clk);
        chk(reload_busy_o == 2'b00, "R12 both cleared", reload_busy_o, 0);
        repeat (300) @(negedge clk);

        // R2 / R5 disable
        wr(4'd4, 32'h0);
        @(negedge clk);
        chk(hcount_o == 0 && vcount_o == 0, "R2 held when disabled", hcount_o, 0);
        chk(hsync_o == 1 && vsync_o == 1 && de_o == 1, "R5 idle levels", {hsync_o, vsync_o, de_o}, 7);
        repeat (5) @(negedge clk);
        summary();
    end
endmodule